// File: doc/BRIEF.md
# Base-3 Trit Byte Unpacker

This block expands densely packed ternary weights for a multiplier-free dot-product engine. Each 8-bit input byte carries five weights, each -1, 0 or +1, stored as the five digits of the byte's value written in base 3. That gives 1.6 bits per weight, against 2 bits per weight for a plain two-bit-per-weight layout. The block splits the byte into digits with a chain of divide-by-3 stages rather than by slicing bit fields. Each digit becomes a 2-bit signed trit code.

A byte enters through a valid/ready handshake. A build-time parameter picks the output form. In serial form the five trits leave one per accepted beat. In parallel form all five leave together on one beat. Byte values above 242 cannot come from packing five trits. Such a byte is flagged as an error and its trits are forced to zero.

Top module: `trit_unpacker`

## Requirements
- R1: During and straight after reset, out_valid is 0 and in_ready is 1.
- R2: Byte value v is decoded into base-3 digits, least significant first. Trit k is digit k of v, and digit d stands for weight d-1. Trit codes are 2'b11 for -1, 2'b00 for 0 and 2'b01 for +1. The code 2'b10 never appears.
- R3: A byte of value 243 to 255 produces out_err = 1 on every one of its beats, with every trit code 2'b00.
- R4: A byte of value 0 to 242 produces out_err = 0 on all of its beats.
- R5: In serial form (PARALLEL = 0) a byte leaves as five beats carrying trit 0 to trit 4 in that order on out_trits[1:0]. out_last is 1 on the fifth beat only.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_trits, out_last and out_err hold their values.
- R7: in_ready is 0 while a byte is still being emitted, except in the cycle where its final beat is taken. In that cycle a waiting byte is accepted, and its first beat appears in the next cycle with no gap.
- R8: In parallel form (PARALLEL = 1) a byte leaves as one beat with out_last = 1. Trit k is in out_trits[2k+1:2k]. A new byte may be accepted in every cycle in which that beat is taken.
- R9: No byte is taken while in_valid is 0, so out_valid stays 0 when nothing is offered.
- R10: An accepted byte's first beat is presented in the cycle after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Packed byte offered |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_byte | input | BYTE_W | Packed byte, five base-3 digits |
| out_valid | output | 1 | Trit beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_trits | output | PARALLEL ? 2*TRITS : 2 | Trit code(s) of the beat |
| out_last | output | 1 | Beat ends the current byte |
| out_err | output | 1 | Current byte was an illegal value |

## Verification
Two things can happen in the same cycle: the final beat of a byte is taken, and the next byte is accepted. The bench provokes this by holding in_valid high with a second byte for the whole time a serial byte is draining. It checks three things. in_ready must stay low through the first four beats. It must rise exactly on the fifth beat. The second byte's first trit must appear on the next cycle with no idle beat. The parallel instance is driven with one byte per cycle, and each beat is checked against the byte that was offered one cycle earlier.

// File: rtl/trit_unpack_pkg.sv
package trit_unpack_pkg;

    localparam int TRITS_PER_BYTE = 5;
    localparam int PACK_BYTE_W    = 8;

    typedef logic [1:0] trit_code_t;

    localparam trit_code_t CODE_NEG  = 2'b11;
    localparam trit_code_t CODE_ZERO = 2'b00;
    localparam trit_code_t CODE_POS  = 2'b01;

    function automatic int pow3(input int n);
        int acc;
        acc = 1;
        for (int i = 0; i < n; i++) acc = acc * 3;
        return acc;
    endfunction

    // a base-3 digit d represents weight d-1
    function automatic trit_code_t digit_to_code(input logic [1:0] d);
        trit_code_t c;
        case (d)
            2'd0:    c = CODE_NEG;
            2'd1:    c = CODE_ZERO;
            2'd2:    c = CODE_POS;
            default: c = CODE_ZERO;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/trit_div3_stage.sv
module trit_div3_stage #(
    parameter int W = 8
) (
    input  logic [W-1:0] num,
    output logic [W-1:0] quot,
    output logic [1:0]   rem
);
    // floor(num/3) by reciprocal multiply; error stays below 1/3 for any W
    localparam int SHIFT  = W + 1;
    localparam int PW     = 2 * W + 2;
    localparam int RECIP  = ((1 << SHIFT) + 2) / 3;

    logic [PW-1:0] prod;

    always_comb begin
        prod = PW'(num) * PW'(RECIP);
        quot = W'(prod >> SHIFT);
        rem  = 2'(num - quot - quot - quot);
    end

    always_comb begin
        if (!$isunknown(num)) begin
            a_rem_range_r2: assert (rem < 2'd3);
        end
    end

endmodule

// File: rtl/trit_byte_decoder.sv
module trit_byte_decoder
    import trit_unpack_pkg::*;
#(
    parameter int TRITS  = TRITS_PER_BYTE,
    parameter int BYTE_W = PACK_BYTE_W
) (
    input  logic [BYTE_W-1:0]          byte_in,
    output trit_code_t [TRITS-1:0]     codes,
    output logic                       illegal
);
    localparam int MAX_LEGAL = pow3(TRITS) - 1;

    logic [BYTE_W-1:0] residue [TRITS+1];
    logic [1:0]        digit   [TRITS];
    trit_code_t [TRITS-1:0] raw_codes;

    assign residue[0] = byte_in;

    for (genvar k = 0; k < TRITS; k++) begin : g_digit
        trit_div3_stage #(.W(BYTE_W)) u_stage (
            .num  (residue[k]),
            .quot (residue[k+1]),
            .rem  (digit[k])
        );
        assign raw_codes[k] = digit_to_code(digit[k]);
    end

    // anything left over after TRITS digits means the value exceeds 3^TRITS-1
    assign illegal = |residue[TRITS];
    assign codes   = illegal ? '0 : raw_codes;

    always_comb begin
        if (!$isunknown(byte_in)) begin
            a_err_match_r3: assert (illegal == (32'(byte_in) > MAX_LEGAL));
        end
    end

endmodule

// File: rtl/trit_beat_sequencer.sv
module trit_beat_sequencer
    import trit_unpack_pkg::*;
#(
    parameter int TRITS    = TRITS_PER_BYTE,
    parameter bit PARALLEL = 1'b0,
    localparam int IDX_W   = (TRITS > 1) ? $clog2(TRITS) : 1,
    localparam int OUT_W   = PARALLEL ? 2 * TRITS : 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  trit_code_t [TRITS-1:0]  load_codes,
    input  logic                    load_err,
    output logic                    can_load,
    output logic                    beat_valid,
    input  logic                    beat_ready,
    output logic [OUT_W-1:0]        beat_data,
    output logic                    beat_last,
    output logic                    beat_err
);
    logic                   busy_q;
    logic [IDX_W-1:0]       idx_q;
    trit_code_t [TRITS-1:0] codes_q;
    logic                   err_q;
    logic                   fire;
    logic                   done;

    if (PARALLEL) begin : g_par
        assign beat_data = codes_q;
        assign beat_last = 1'b1;
    end else begin : g_ser
        assign beat_data = codes_q[idx_q];
        assign beat_last = (idx_q == IDX_W'(TRITS - 1));
    end

    assign fire       = busy_q && beat_ready;
    assign done       = fire && beat_last;
    assign can_load   = !busy_q || done;
    assign beat_valid = busy_q;
    assign beat_err   = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            idx_q   <= '0;
            codes_q <= '0;
            err_q   <= 1'b0;
        end else if (load) begin
            busy_q  <= 1'b1;
            idx_q   <= '0;
            codes_q <= load_codes;
            err_q   <= load_err;
        end else if (done) begin
            busy_q  <= 1'b0;
            idx_q   <= '0;
        end else if (fire) begin
            idx_q   <= idx_q + 1'b1;
        end
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        busy_q && !beat_ready |=> busy_q && $stable(beat_data) && $stable(beat_last) && $stable(beat_err));

    p_mid_beat_r5: assert property (@(posedge clk) disable iff (rst)
        fire && !beat_last |=> busy_q);

    p_err_zero_r3: assert property (@(posedge clk) disable iff (rst)
        busy_q && err_q |-> beat_data == '0);

endmodule

// File: rtl/trit_unpacker.sv
module trit_unpacker
    import trit_unpack_pkg::*;
#(
    parameter int TRITS    = TRITS_PER_BYTE,
    parameter int BYTE_W   = PACK_BYTE_W,
    parameter bit PARALLEL = 1'b0
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  in_valid,
    output logic                                  in_ready,
    input  logic [BYTE_W-1:0]                     in_byte,
    output logic                                  out_valid,
    input  logic                                  out_ready,
    output logic [(PARALLEL ? 2*TRITS : 2)-1:0]   out_trits,
    output logic                                  out_last,
    output logic                                  out_err
);
    localparam int OUT_W   = PARALLEL ? 2 * TRITS : 2;
    localparam int N_LANES = OUT_W / 2;

    trit_code_t [TRITS-1:0] dec_codes;
    logic                   dec_illegal;
    logic                   can_load;
    logic                   load;

    trit_byte_decoder #(.TRITS(TRITS), .BYTE_W(BYTE_W)) u_decoder (
        .byte_in (in_byte),
        .codes   (dec_codes),
        .illegal (dec_illegal)
    );

    assign in_ready = can_load;
    assign load     = in_valid && can_load;

    trit_beat_sequencer #(.TRITS(TRITS), .PARALLEL(PARALLEL)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_codes (dec_codes),
        .load_err   (dec_illegal),
        .can_load   (can_load),
        .beat_valid (out_valid),
        .beat_ready (out_ready),
        .beat_data  (out_trits),
        .beat_last  (out_last),
        .beat_err   (out_err)
    );

    p_busy_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && !(out_ready && out_last) |-> !in_ready);

    p_take_shows_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    p_idle_stays_r9: assert property (@(posedge clk) disable iff (rst)
        !out_valid && !in_valid |=> !out_valid);

    for (genvar k = 0; k < N_LANES; k++) begin : g_lane_chk
        p_code_legal_r2: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> out_trits[2*k +: 2] != 2'b10);
    end

    if (PARALLEL) begin : g_par_chk
        p_single_beat_r8: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> out_last);
    end

endmodule

// File: tb/trit_unpacker_test.sv
module trit_unpacker_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] in_byte;
    logic       in_valid_s, in_ready_s, out_valid_s, out_ready_s, out_last_s, out_err_s;
    logic [1:0] out_trits_s;
    logic       in_valid_p, in_ready_p, out_valid_p, out_ready_p, out_last_p, out_err_p;
    logic [9:0] out_trits_p;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    trit_unpacker #(.TRITS(5), .BYTE_W(8), .PARALLEL(1'b0)) uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid_s), .in_ready(in_ready_s), .in_byte(in_byte),
        .out_valid(out_valid_s), .out_ready(out_ready_s),
        .out_trits(out_trits_s), .out_last(out_last_s), .out_err(out_err_s)
    );

    trit_unpacker #(.TRITS(5), .BYTE_W(8), .PARALLEL(1'b1)) uut_p (
        .clk(clk), .rst(rst),
        .in_valid(in_valid_p), .in_ready(in_ready_p), .in_byte(in_byte),
        .out_valid(out_valid_p), .out_ready(out_ready_p),
        .out_trits(out_trits_p), .out_last(out_last_p), .out_err(out_err_p)
    );

    localparam int NVEC = 12;
    localparam logic [7:0] VEC [NVEC] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd80, 8'd121,
                                          8'd122, 8'd242, 8'd243, 8'd250, 8'd255, 8'd200};

    function automatic logic [1:0] exp_trit(input int v, input int k);
        int r;
        int d;
        if (v > 242) return 2'b00;
        r = v;
        for (int j = 0; j < k; j++) r = r / 3;
        d = r % 3;
        return (d == 0) ? 2'b11 : ((d == 1) ? 2'b00 : 2'b01);
    endfunction

    function automatic logic [9:0] exp_all(input int v);
        logic [9:0] w;
        for (int k = 0; k < 5; k++) w[2*k +: 2] = exp_trit(v, k);
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_serial_beat(input int v, input int k, input string req);
        chk(out_valid_s === 1'b1, {req, " serial valid"}, 32'(out_valid_s), 1);
        chk(out_trits_s === exp_trit(v, k), {req, " serial trit"}, 32'(out_trits_s), 32'(exp_trit(v, k)));
        chk(out_last_s === (k == 4), {"R5 last marker"}, 32'(out_last_s), 32'(k == 4));
        chk(out_err_s === (v > 242), {"R3/R4 serial err"}, 32'(out_err_s), 32'(v > 242));
    endtask

    task automatic chk_par_beat(input int v, input string req);
        chk(out_valid_p === 1'b1, {req, " par valid"}, 32'(out_valid_p), 1);
        chk(out_trits_p === exp_all(v), {req, " par trits"}, 32'(out_trits_p), 32'(exp_all(v)));
        chk(out_last_p === 1'b1, "R8 par last", 32'(out_last_p), 1);
        chk(out_err_p === (v > 242), "R3/R4 par err", 32'(out_err_p), 32'(v > 242));
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        rst = 1'b1;
        in_byte = 8'd0;
        in_valid_s = 1'b0; in_valid_p = 1'b0;
        out_ready_s = 1'b1; out_ready_p = 1'b1;
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        chk(out_valid_s === 1'b0 && out_valid_p === 1'b0, "R1 valid in reset", 32'(out_valid_s), 0);
        chk(in_ready_s === 1'b1 && in_ready_p === 1'b1, "R1 ready in reset", 32'(in_ready_s), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid_s === 1'b0 && in_ready_s === 1'b1, "R1 after reset", 32'(out_valid_s), 0);

        // R9: nothing offered, nothing emitted
        for (int i = 0; i < 3; i++) begin
            in_byte = 8'd55;
            @(negedge clk);
            chk(out_valid_s === 1'b0 && out_valid_p === 1'b0, "R9 idle", 32'(out_valid_s), 0);
        end

        // vector table: R2, R3, R4, R5, R8, R10
        for (int i = 0; i < NVEC; i++) begin
            in_byte = VEC[i];
            in_valid_s = 1'b1; in_valid_p = 1'b1;
            @(negedge clk);
            in_valid_s = 1'b0; in_valid_p = 1'b0;
            chk_par_beat(int'(VEC[i]), "R2 R8 R10");
            for (int k = 0; k < 5; k++) begin
                chk_serial_beat(int'(VEC[i]), k, "R2 R10");
                @(negedge clk);
            end
            chk(out_valid_s === 1'b0 && out_valid_p === 1'b0, "R5 drained", 32'(out_valid_s), 0);
        end

        // R6 stall and R7 blocked input (100 = digits 1,0,2,0,1)
        in_byte = 8'd100; in_valid_s = 1'b1; out_ready_s = 1'b0;
        @(negedge clk);
        in_byte = 8'd7;
        for (int i = 0; i < 3; i++) begin
            chk_serial_beat(100, 0, "R6 stall");
            chk(in_ready_s === 1'b0, "R7 ready low while busy", 32'(in_ready_s), 0);
            @(negedge clk);
        end
        in_valid_s = 1'b0; out_ready_s = 1'b1;
        for (int k = 0; k < 5; k++) begin
            chk_serial_beat(100, k, "R6 after stall");
            @(negedge clk);
        end
        chk(out_valid_s === 1'b0, "R7 offered byte not taken", 32'(out_valid_s), 0);

        // R7 back-to-back: final beat and next acceptance in one cycle
        in_byte = 8'd50; in_valid_s = 1'b1;
        @(negedge clk);
        in_byte = 8'd200;
        for (int k = 0; k < 5; k++) begin
            chk_serial_beat(50, k, "R7 first byte");
            chk(in_ready_s === (k == 4), "R7 ready only on final beat", 32'(in_ready_s), 32'(k == 4));
            @(negedge clk);
        end
        in_valid_s = 1'b0;
        for (int k = 0; k < 5; k++) begin
            chk_serial_beat(200, k, "R7 no gap");
            @(negedge clk);
        end

        // R8 parallel back-to-back, legal then illegal
        in_byte = 8'd17; in_valid_p = 1'b1;
        @(negedge clk);
        in_byte = 8'd243;
        chk_par_beat(17, "R8 first");
        chk(in_ready_p === 1'b1, "R8 ready with beat taken", 32'(in_ready_p), 1);
        @(negedge clk);
        in_valid_p = 1'b0;
        chk_par_beat(243, "R8 R3 second");
        @(negedge clk);
        chk(out_valid_p === 1'b0, "R8 drained", 32'(out_valid_p), 0);

        // R6 parallel stall
        in_byte = 8'd241; in_valid_p = 1'b1; out_ready_p = 1'b0;
        @(negedge clk);
        in_valid_p = 1'b0;
        for (int i = 0; i < 2; i++) begin
            chk_par_beat(241, "R6 par stall");
            @(negedge clk);
        end
        out_ready_p = 1'b1;
        @(negedge clk);
        chk(out_valid_p === 1'b0, "R6 par released", 32'(out_valid_p), 0);

        finish_run();
    end

endmodule